// File: doc/BRIEF.md
# Accumulator-Addressed Output Port Selector

This block sits between an instruction sequencer and a set of output devices. It sends one output write to the device named in the upper bits of the 16-bit accumulator word. Code 0 names the serial terminal. Codes 1 to 4 name four 8-bit parallel ports. Codes 5 to 7 name three 10-bit converter ports. Any other code names no device. Because code 0 is the terminal, older code that only ever writes 8-bit characters keeps working.

Two instructions reach the block. The direct-output instruction strobes the addressed port in the same cycle and never looks at readiness. The legacy put-character instruction always targets the terminal. It waits while the serial transmitter reports busy, and then sends the low byte it captured when the request arrived. A one-cycle done pulse tells the sequencer that either instruction has completed. Each port keeps its data bus at the value of its last write.

Top module: `outsel_top`

## Requirements
- R1: While reset is active and in the first cycle after it, all strobes, `done` and `bad_dev` are 0 and every port data bus reads 0.
- R2: A direct request (`op_direct`=1, no put-character request and none pending) whose code `acc[15:12]` is 0 pulses `term_wr` in the same cycle, with `term_data` = `acc[7:0]`. This happens whatever the value of `tx_busy`.
- R3: A direct request with code c in 1..4 pulses `par_wr[c-1]` in the same cycle, with `par_data[8*(c-1) +: 8]` = `acc[7:0]`.
- R4: A direct request with code c in 5..7 pulses `cnv_wr[c-5]` in the same cycle, with `cnv_data[10*(c-5) +: 10]` = `acc[9:0]`. Accumulator bits 10 and 11 are dropped.
- R5: A direct request with code 8..15 produces no strobe and pulses `bad_dev` in the same cycle.
- R6: At most one strobe is high in any cycle. A strobe lasts one cycle per accepted request. A port data bus keeps its last written value until that same port is written again.
- R7: A put-character request (`op_putc`=1) while `tx_busy`=0 pulses `term_wr` in the same cycle, with `term_data` = `acc[7:0]`.
- R8: A put-character request while `tx_busy`=1 captures `acc[7:0]` and stalls. No strobe and no `done` appear while `tx_busy` stays 1. The captured byte is written to the terminal in the first cycle in which `tx_busy` is 0.
- R9: A put-character request ignores `acc[15:8]`: a non-zero code never strobes a parallel or converter port and never raises `bad_dev`.
- R10: While a put-character request is pending, new requests are ignored. When `op_putc` and `op_direct` are high in the same cycle, the put-character request is served and the direct request is dropped.
- R11: `done` pulses for exactly one cycle, in the cycle in which an accepted instruction completes: a strobe, a `bad_dev` pulse, or a put-character write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_direct | input | 1 | Direct-output request, one cycle |
| op_putc | input | 1 | Put-character request, one cycle |
| acc | input | 16 | Accumulator word: device code in [15:12], data in the low bits |
| tx_busy | input | 1 | Serial transmitter busy |
| term_data | output | 8 | Terminal data bus |
| term_wr | output | 1 | Terminal write strobe |
| par_data | output | 32 | Four 8-bit parallel data buses, port k in [8k+7:8k] |
| par_wr | output | 4 | Parallel port write strobes |
| cnv_data | output | 30 | Three 10-bit converter data buses, port k in [10k+9:10k] |
| cnv_wr | output | 3 | Converter write strobes |
| bad_dev | output | 1 | Invalid device code on a direct request |
| done | output | 1 | Instruction completed |

## Verification
The hardest case to reach is the put-character request that is left pending while the transmitter stays busy. The stimulus holds `tx_busy` high for several cycles and checks each cycle that no strobe and no `done` appear. During that wait it issues a direct request with a different accumulator word, and only then releases the transmitter. The scoreboard then expects exactly one terminal write carrying the byte captured at request time, with the parallel port the direct request named left unchanged. A separate cycle raises both requests at once to show that the put-character request wins.

// File: rtl/outsel_pkg.sv
// Package: shared defaults for the accumulator-addressed output selector.
// Assumes the device code occupies the top bits of the accumulator word.
package outsel_pkg;
    localparam int ACC_W_D  = 16;  // accumulator width
    localparam int SEL_W_D  = 4;   // device-code width
    localparam int BYTE_W   = 8;   // terminal character width
    localparam int PAR_W_D  = 8;   // parallel port width
    localparam int CNV_W_D  = 10;  // converter port width
    localparam int N_PAR_D  = 4;   // number of parallel ports
    localparam int N_CNV_D  = 3;   // number of converter ports
    localparam int PAR_BASE = 1;   // first parallel port code
endpackage

// File: rtl/outsel_decode.sv
// Module: outsel_decode
// Turns a device code into one-hot port hits plus an invalid flag.
// Assumes code 0 = terminal, then N_PAR parallel codes, then N_CNV
// converter codes; every code above that is invalid.
module outsel_decode #(
    parameter int SEL_W = 4,
    parameter int N_PAR = 4,
    parameter int N_CNV = 3
) (
    input  logic [SEL_W-1:0] code,
    output logic             term_hit,
    output logic [N_PAR-1:0] par_hit,
    output logic [N_CNV-1:0] cnv_hit,
    output logic             invalid
);
    localparam int CNV_BASE = outsel_pkg::PAR_BASE + N_PAR;
    localparam int LAST     = CNV_BASE + N_CNV - 1;

    // terminal match
    assign term_hit = (code == '0);

    // parallel port matches
    for (genvar i = 0; i < N_PAR; i++) begin : g_par
        assign par_hit[i] = (code == SEL_W'(outsel_pkg::PAR_BASE + i));
    end

    // converter port matches
    for (genvar j = 0; j < N_CNV; j++) begin : g_cnv
        assign cnv_hit[j] = (code == SEL_W'(CNV_BASE + j));
    end

    // codes past the last port
    assign invalid = (32'(code) > LAST);
endmodule

// File: rtl/outsel_putc.sv
// Module: outsel_putc
// Put-character unit: fires at once when the transmitter is idle, otherwise
// captures the byte and waits for idle. Assumes req is ignored while pending.
module outsel_putc #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req,
    input  logic         tx_busy,
    input  logic [W-1:0] byte_in,
    output logic         fire,
    output logic [W-1:0] byte_out,
    output logic         pending
);
    logic [W-1:0] held_q;

    // capture the byte on a stalled request; clear once it is sent
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            held_q  <= '0;
        end else if (!pending && req && tx_busy) begin
            pending <= 1'b1;
            held_q  <= byte_in;
        end else if (pending && !tx_busy) begin
            pending <= 1'b0;
        end
    end

    // send when idle, from the held byte or straight through
    always_comb begin
        fire     = !tx_busy && (pending || req);
        byte_out = pending ? held_q : byte_in;
    end
endmodule

// File: rtl/outsel_hold.sv
// Module: outsel_hold
// One output port: the strobe passes straight through, and the data bus shows
// the incoming word during a write and the last written word otherwise.
module outsel_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] q;

    // remember the last written word
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (wr) q <= din;
    end

    // present the write data in the strobe cycle
    assign dout = wr ? din : q;
endmodule

// File: rtl/outsel_top.sv
// Module: outsel_top
// Routes output writes to the terminal, parallel or converter ports, chosen by
// the top bits of the accumulator. Direct requests strobe at once; put-character
// requests always go to the terminal and wait for the transmitter to be idle.
// Assumes requests are one-cycle pulses from a sequencer that waits for done.
module outsel_top #(
    parameter int ACC_W = outsel_pkg::ACC_W_D,
    parameter int SEL_W = outsel_pkg::SEL_W_D,
    parameter int PAR_W = outsel_pkg::PAR_W_D,
    parameter int CNV_W = outsel_pkg::CNV_W_D,
    parameter int N_PAR = outsel_pkg::N_PAR_D,
    parameter int N_CNV = outsel_pkg::N_CNV_D
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   op_direct,
    input  logic                   op_putc,
    input  logic [ACC_W-1:0]       acc,
    input  logic                   tx_busy,
    output logic [7:0]             term_data,
    output logic                   term_wr,
    output logic [N_PAR*PAR_W-1:0] par_data,
    output logic [N_PAR-1:0]       par_wr,
    output logic [N_CNV*CNV_W-1:0] cnv_data,
    output logic [N_CNV-1:0]       cnv_wr,
    output logic                   bad_dev,
    output logic                   done
);
    localparam int BW = outsel_pkg::BYTE_W;

    logic [SEL_W-1:0] code;
    logic             term_hit, invalid, direct_ok;
    logic [N_PAR-1:0] par_hit;
    logic [N_CNV-1:0] cnv_hit;
    logic             putc_fire, putc_pend;
    logic [BW-1:0]    putc_byte, term_din;

    assign code = acc[ACC_W-1 -: SEL_W];

    outsel_decode #(.SEL_W(SEL_W), .N_PAR(N_PAR), .N_CNV(N_CNV)) dec_i (
        .code(code), .term_hit(term_hit), .par_hit(par_hit),
        .cnv_hit(cnv_hit), .invalid(invalid)
    );

    outsel_putc #(.W(BW)) putc_i (
        .clk(clk), .rst_n(rst_n), .req(op_putc), .tx_busy(tx_busy),
        .byte_in(acc[BW-1:0]), .fire(putc_fire), .byte_out(putc_byte),
        .pending(putc_pend)
    );

    // direct request accepted only with no put-character in flight
    always_comb begin
        direct_ok = op_direct && !op_putc && !putc_pend;
        term_wr   = putc_fire || (direct_ok && term_hit);
        term_din  = putc_fire ? putc_byte : acc[BW-1:0];
        par_wr    = direct_ok ? par_hit : '0;
        cnv_wr    = direct_ok ? cnv_hit : '0;
        bad_dev   = direct_ok && invalid;
        done      = putc_fire || direct_ok;
    end

    outsel_hold #(.W(BW)) term_i (
        .clk(clk), .rst_n(rst_n), .wr(term_wr), .din(term_din), .dout(term_data)
    );

    for (genvar i = 0; i < N_PAR; i++) begin : g_par
        outsel_hold #(.W(PAR_W)) par_i (
            .clk(clk), .rst_n(rst_n), .wr(par_wr[i]), .din(acc[PAR_W-1:0]),
            .dout(par_data[i*PAR_W +: PAR_W])
        );
    end

    for (genvar j = 0; j < N_CNV; j++) begin : g_cnv
        outsel_hold #(.W(CNV_W)) cnv_i (
            .clk(clk), .rst_n(rst_n), .wr(cnv_wr[j]), .din(acc[CNV_W-1:0]),
            .dout(cnv_data[j*CNV_W +: CNV_W])
        );
    end
endmodule

// File: rtl/outsel_chk.sv
// Module: outsel_chk
// Property checker for outsel_top, attached by bind. Observes ports only.
module outsel_chk #(
    parameter int N_PAR = 4,
    parameter int N_CNV = 3,
    parameter int PAR_W = 8,
    parameter int CNV_W = 10
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   op_direct,
    input logic                   tx_busy,
    input logic                   term_wr,
    input logic [N_PAR*PAR_W-1:0] par_data,
    input logic [N_PAR-1:0]       par_wr,
    input logic [N_CNV*CNV_W-1:0] cnv_data,
    input logic [N_CNV-1:0]       cnv_wr,
    input logic                   bad_dev,
    input logic                   done
);
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({term_wr, par_wr, cnv_wr, bad_dev}));                    // R6
    AST_BAD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        bad_dev |-> (!term_wr && par_wr == '0 && cnv_wr == '0));          // R5
    AST_STROBE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (term_wr || par_wr != '0 || cnv_wr != '0 || bad_dev) |-> done);   // R11
    AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (term_wr || par_wr != '0 || cnv_wr != '0 || bad_dev));   // R11
    AST_PUTC_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_busy && !op_direct) |-> !term_wr);                            // R8
    AST_PAR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !par_wr[0] |=> (par_wr[0] || $stable(par_data[PAR_W-1:0])));      // R6
    AST_CNV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cnv_wr[0] |=> (cnv_wr[0] || $stable(cnv_data[CNV_W-1:0])));      // R6
endmodule

bind outsel_top outsel_chk #(
    .N_PAR(N_PAR), .N_CNV(N_CNV), .PAR_W(PAR_W), .CNV_W(CNV_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .op_direct(op_direct), .tx_busy(tx_busy),
    .term_wr(term_wr), .par_data(par_data), .par_wr(par_wr),
    .cnv_data(cnv_data), .cnv_wr(cnv_wr), .bad_dev(bad_dev), .done(done)
);

// File: tb/outsel_top_tb_top.sv
// Scoreboard bench for outsel_top: the driver pushes expected events, and the
// monitor pops and compares them at each falling edge.
module outsel_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_direct = 1'b0, op_putc = 1'b0, tx_busy = 1'b0;
    logic [15:0] acc = '0;
    logic [7:0]  term_data;
    logic        term_wr, bad_dev, done;
    logic [31:0] par_data;
    logic [3:0]  par_wr;
    logic [29:0] cnv_data;
    logic [2:0]  cnv_wr;

    always #5 clk = ~clk;

    outsel_top dut_i (
        .clk(clk), .rst_n(rst_n), .op_direct(op_direct), .op_putc(op_putc),
        .acc(acc), .tx_busy(tx_busy), .term_data(term_data), .term_wr(term_wr),
        .par_data(par_data), .par_wr(par_wr), .cnv_data(cnv_data),
        .cnv_wr(cnv_wr), .bad_dev(bad_dev), .done(done)
    );

    typedef struct { int id; logic [31:0] data; string tag; } exp_t;
    exp_t sb[$];
    int total = 0, bad = 0, cyc = 0;

    function automatic void check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endfunction

    function automatic void push(int id, logic [31:0] data, string tag);
        exp_t e;
        e.id = id; e.data = data; e.tag = tag;
        sb.push_back(e);
    endfunction

    // monitor: ids 0 terminal, 1-4 parallel, 5-7 converter, 8 invalid
    always @(negedge clk) begin
        int oid;
        logic [31:0] od;
        exp_t e;
        if (rst_n && (done || term_wr || par_wr != 0 || cnv_wr != 0 || bad_dev)) begin
            oid = -1; od = 0;
            if (term_wr) begin oid = 0; od = 32'(term_data); end
            for (int i = 0; i < 4; i++)
                if (par_wr[i]) begin oid = 1 + i; od = 32'(par_data[8*i +: 8]); end
            for (int j = 0; j < 3; j++)
                if (cnv_wr[j]) begin oid = 5 + j; od = 32'(cnv_data[10*j +: 10]); end
            if (bad_dev) oid = 8;
            check("R6 single event", 32'($countones({term_wr, par_wr, cnv_wr, bad_dev})), 1);
            check("R11 done with event", 32'(done), 1);
            if (sb.size() == 0) begin
                check("R10 unexpected event id", 32'(oid), 32'(-1));
            end else begin
                e = sb.pop_front();
                check({e.tag, " port"}, 32'(oid), 32'(e.id));
                check({e.tag, " data"}, od, e.data);
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000) begin
            total++; bad++;
            $display("FAIL watchdog act=%0d exp=<5000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic direct(logic [3:0] code, logic [11:0] val, string tag);
        int id;
        id = int'(code);
        acc = {code, val};
        op_direct = 1'b1;
        if (id == 0 || (id >= 1 && id <= 4)) push(id, 32'(val[7:0]), tag);
        else if (id <= 7) push(id, 32'(val[9:0]), tag);
        else push(8, 32'(od_none()), tag);
        step();
        op_direct = 1'b0;
    endtask

    function automatic logic [31:0] od_none();
        return 32'd0;
    endfunction

    initial begin
        repeat (3) step();
        @(negedge clk);
        check("R1 reset strobes", 32'({term_wr, par_wr, cnv_wr, bad_dev, done}), 0);
        check("R1 reset par_data", par_data, 0);
        check("R1 reset cnv_data", 32'(cnv_data), 0);
        step();
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", 32'({term_wr, par_wr, cnv_wr, bad_dev, done, term_data}), 0);
        step();

        tx_busy = 1'b1;
        direct(4'd0, 12'hA5A, "R2 terminal direct while busy");
        tx_busy = 1'b0;
        direct(4'd1, 12'hF11, "R3 par0");
        direct(4'd2, 12'h022, "R3 par1");
        direct(4'd3, 12'h733, "R3 par2");
        direct(4'd4, 12'h044, "R3 par3");
        direct(4'd5, 12'hFC5, "R4 cnv0 drops bits 11:10");
        direct(4'd6, 12'h2A6, "R4 cnv1");
        direct(4'd7, 12'h1FF, "R4 cnv2");
        direct(4'd9, 12'h123, "R5 code 9 invalid");
        direct(4'd15, 12'hFFF, "R5 code 15 invalid");
        step();
        @(negedge clk);
        check("R6 par hold", par_data, 32'h44332211);
        check("R6 cnv2 hold", 32'(cnv_data[29:20]), 32'h1FF);
        check("R6 cnv0 hold", 32'(cnv_data[9:0]), 32'h3C5);
        step();

        // put-character, idle transmitter, non-zero code bits
        acc = 16'h7341; op_putc = 1'b1;
        push(0, 32'h41, "R7 putc idle");
        step();
        op_putc = 1'b0;
        @(negedge clk);
        check("R9 cnv2 untouched by putc", 32'(cnv_data[29:20]), 32'h1FF);
        step();

        // put-character stalled, direct ignored while pending
        tx_busy = 1'b1; acc = 16'h3522; op_putc = 1'b1;
        push(0, 32'h22, "R8 putc after busy");
        @(negedge clk);
        check("R8 no done while busy", 32'(done), 0);
        step();
        op_putc = 1'b0; acc = 16'h10EE; op_direct = 1'b1;
        @(negedge clk);
        check("R10 direct ignored while pending", 32'(par_wr), 0);
        step();
        op_direct = 1'b0; acc = 16'h0000;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R8 still stalled", 32'({done, term_wr}), 0);
            step();
        end
        tx_busy = 1'b0;
        step();
        @(negedge clk);
        check("R10 par0 unchanged", 32'(par_data[7:0]), 32'h11);
        check("R9 no bad_dev on putc", 32'(bad_dev), 0);
        step();

        // both requests in the same cycle
        acc = 16'h2077; op_putc = 1'b1; op_direct = 1'b1;
        push(0, 32'h77, "R10 putc wins over direct");
        step();
        op_putc = 1'b0; op_direct = 1'b0;
        @(negedge clk);
        check("R10 par1 unchanged", 32'(par_data[15:8]), 32'h22);
        step(); step();
        check("scoreboard drained", 32'(sb.size()), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule